// File: doc/BRIEF.md
# Windowed Bidirectional Bit Shift Register

The block keeps a bank of single-bit relays (256 by default). A contiguous slice of that bank is the shifting window. Its lowest index is set by a start input and its size by a length input, both read at run time. On each rising edge of a pulse input the window moves by one place. In forward mode it moves toward higher indices and the serial bit enters at the low end. In reverse mode it moves toward lower indices and the serial bit enters at the high end. Bits outside the window are left alone. Software-style logic around the block can still set those bits one at a time through a write port.

A clear input empties the window. A system reset models power-up. It empties the whole bank unless a retention mode bit asks for the contents to be kept. If a power-down request arrives while a detected pulse edge is waiting to be applied, that shift is abandoned and a sticky interruption flag is raised. The full bank is always visible on a parallel output.

Top module: `windowed_shift_bank`

## Requirements
- R1: While `rst_n` is low, every bank bit is 0 and `shift_int` is 0 when `retain` is 0. When `retain` is 1, the bank keeps its contents and `shift_int` is still cleared.
- R2: The window covers indices `head` through `head+len-1`. `cfg_err` is 1 exactly when `len` is 0 or `head+len` exceeds 256, and it follows those inputs with no clock delay.
- R3: A 0-to-1 change of `pulse` gives exactly one shift. The shift shows on `bank` after the second rising clock edge at which `pulse` is seen high. Holding `pulse` high gives no further shift.
- R4: In a forward shift (`rev`=0), `bank[head]` takes `din` and every other window bit takes the value of the bit just below it.
- R5: In a reverse shift (`rev`=1), `bank[head+len-1]` takes `din` and every other window bit takes the value of the bit just above it.
- R6: `clr` high at a clock edge zeroes every window bit at that edge. It overrides a shift due at the same edge.
- R7: A shift due while `cfg_err` is 1 leaves the bank unchanged.
- R8: A shift or a clear never changes a bit outside the window.
- R9: `wr_en` high at a clock edge loads `wr_data` into `bank[wr_addr]` when that index is outside the window. The write is ignored when the index is inside the window.
- R10: A shift due at an edge where `pwr_down` is 1 is dropped and `shift_int` goes to 1. `shift_int` then stays at 1 until `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| retain | input | 1 | Keep bank contents through `rst_n` |
| clr | input | 1 | Clear the window |
| pulse | input | 1 | Shift trigger, rising edge |
| din | input | 1 | Serial bit shifted into the window |
| rev | input | 1 | 0 forward, 1 reverse |
| head | input | 8 | Lowest window index |
| len | input | 9 | Window length |
| wr_en | input | 1 | Single-bit write strobe |
| wr_addr | input | 8 | Write index |
| wr_data | input | 1 | Write value |
| pwr_down | input | 1 | Power-down request |
| bank | output | 256 | Parallel view of all bits |
| cfg_err | output | 1 | Window does not fit in the bank |
| shift_int | output | 1 | Sticky flag: a shift was interrupted |

## Verification
A shift appears two clock edges after the pulse is first driven high. One edge registers the edge detection and the next updates the bank. Writes, clears and the falling of `rst_n` show one edge later, or at once for the reset. `cfg_err` is combinational and is read on the next sample. The driver stamps every expected bank image with the cycle number at which it is due. The monitor compares it at the falling clock edge of that cycle, while inputs are driven a little after the falling edge, so samples never meet a changing input. Holding the pulse high is checked with a second image several cycles later that must match the first.

// File: rtl/windowed_shift_bank.sv
module windowed_shift_bank #(
  parameter int NBITS = 256,
  localparam int IW = $clog2(NBITS),
  localparam int LW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retain,
  input  logic             clr,
  input  logic             pulse,
  input  logic             din,
  input  logic             rev,
  input  logic [IW-1:0]    head,
  input  logic [LW-1:0]    len,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_addr,
  input  logic             wr_data,
  input  logic             pwr_down,
  output logic [NBITS-1:0] bank,
  output logic             cfg_err,
  output logic             shift_int
);

  logic [LW:0]      tail_x;
  logic [IW-1:0]    last;
  logic [NBITS-1:0] win, nxt;
  logic             pulse_q, pend, do_shift;

  assign tail_x   = {2'b00, head} + {1'b0, len};
  assign last     = IW'(tail_x - 1'b1);
  assign cfg_err  = (len == '0) || (tail_x > (LW+1)'(NBITS));
  assign do_shift = pend && !cfg_err && !pwr_down;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic from_lo, from_hi, shifted;
    assign win[i] = ((LW+1)'(i) >= {2'b00, head}) && ((LW+1)'(i) < tail_x);
    if (i == 0) begin : g_lo_edge
      assign from_lo = din;
    end else begin : g_lo
      assign from_lo = (head == IW'(i)) ? din : bank[i-1];
    end
    if (i == NBITS-1) begin : g_hi_edge
      assign from_hi = din;
    end else begin : g_hi
      assign from_hi = (last == IW'(i)) ? din : bank[i+1];
    end
    assign shifted = rev ? from_hi : from_lo;
    assign nxt[i] = (clr && win[i])                           ? 1'b0    :
                    (do_shift && win[i])                      ? shifted :
                    (wr_en && !win[i] && wr_addr == IW'(i))   ? wr_data :
                                                                bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q   <= 1'b1;
      pend      <= 1'b0;
      shift_int <= 1'b0;
      if (!retain) bank <= '0;
    end else begin
      pulse_q <= pulse;
      pend    <= pulse && !pulse_q;
      bank    <= nxt;
      if (pend && pwr_down) shift_int <= 1'b1;
    end
  end

  p_one_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend);

  p_fwd_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cfg_err && !pwr_down && !clr && !rev) |=> bank[$past(head)] == $past(din));

  p_rev_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cfg_err && !pwr_down && !clr && rev) |=> bank[$past(last)] == $past(din));

  p_clr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bank & $past(win)) == '0);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cfg_err && !clr && !wr_en) |=> $stable(bank));

  p_outside_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((bank ^ $past(bank)) & ~$past(win)) == '0);

  p_intr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pwr_down) |=> shift_int);

  p_intr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_int |=> shift_int);

endmodule

// File: tb/test_windowed_shift_bank.sv
module test_windowed_shift_bank;
  logic clk = 1'b0;
  logic rst_n, retain, clr, pulse, din, rev, wr_en, wr_data, pwr_down;
  logic [7:0] head, wr_addr;
  logic [8:0] len;
  logic [255:0] bank;
  logic cfg_err, shift_int;

  windowed_shift_bank i_windowed_shift_bank (
    .clk(clk), .rst_n(rst_n), .retain(retain), .clr(clr), .pulse(pulse),
    .din(din), .rev(rev), .head(head), .len(len), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwr_down(pwr_down),
    .bank(bank), .cfg_err(cfg_err), .shift_int(shift_int));

  always #10 clk = ~clk;

  typedef struct {
    string        r;
    int           due;
    logic [255:0] b;
    logic         f;
    logic         e;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  int hb = 0, lb = 1;
  logic [255:0] m = '0;
  logic mflag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic exp_err();
    return (lb == 0) || (hb + lb > 256);
  endfunction

  function automatic logic [255:0] m_fwd(logic [255:0] b, logic d);
    for (int k = hb + lb - 1; k > hb; k--) b[k] = b[k-1];
    b[hb] = d;
    return b;
  endfunction

  function automatic logic [255:0] m_rev(logic [255:0] b, logic d);
    for (int k = hb; k < hb + lb - 1; k++) b[k] = b[k+1];
    b[hb+lb-1] = d;
    return b;
  endfunction

  function automatic logic in_win(int a);
    return (a >= hb) && (a < hb + lb);
  endfunction

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic push(string r, int d);
    item_t it;
    it.r = r; it.due = cyc + d; it.b = m; it.f = mflag; it.e = exp_err();
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bank !== it.b || shift_int !== it.f || cfg_err !== it.e) begin
        fails++;
        $display("FAIL %s: bank=%h flag=%b err=%b expected bank=%h flag=%b err=%b",
                 it.r, bank, shift_int, cfg_err, it.b, it.f, it.e);
      end
    end
  end

  task automatic set_cfg(int h, int l, string r);
    head = 8'(h); len = 9'(l); hb = h; lb = l;
    push(r, 1);
    step();
  endtask

  task automatic wr(int a, logic v, string r);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = v;
    if (!in_win(a)) m[a] = v;
    push(r, 1);
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_pulse(logic d, logic r_, string r);
    din = d; rev = r_; pulse = 1'b1;
    if (!exp_err()) m = r_ ? m_rev(m, d) : m_fwd(m, d);
    push(r, 2);
    step(); step();
    pulse = 1'b0;
    step();
  endtask

  task automatic clr_win(string r);
    clr = 1'b1;
    for (int k = hb; k < hb + lb && k < 256; k++) m[k] = 1'b0;
    push(r, 1);
    step();
    clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retain = 1'b0; clr = 1'b0; pulse = 1'b0; din = 1'b0;
    rev = 1'b0; wr_en = 1'b0; wr_data = 1'b0; pwr_down = 1'b0;
    head = 8'd0; len = 9'd1; wr_addr = 8'd0;
    step();
    push("R1 power-up clears bank", 1);
    step(); step();
    rst_n = 1'b1;
    step();

    set_cfg(4, 8, "R2 window 4..11 valid");
    wr(0, 1'b1, "R9 write below window");
    wr(20, 1'b1, "R9 write above window");
    wr(6, 1'b1, "R9 write inside window ignored");

    do_pulse(1'b1, 1'b0, "R4 forward din=1");
    do_pulse(1'b0, 1'b0, "R4 forward din=0");
    do_pulse(1'b1, 1'b0, "R4 forward din=1 again");
    do_pulse(1'b1, 1'b0, "R8 outside kept after forward shift");

    // R3: pulse held high shifts once only
    din = 1'b1; rev = 1'b0; pulse = 1'b1;
    m = m_fwd(m, 1'b1);
    push("R3 first edge shifts", 2);
    step(); step();
    din = 1'b0;
    step(); step(); step();
    push("R3 held pulse no more shifts", 1);
    step();
    pulse = 1'b0;
    step();

    do_pulse(1'b0, 1'b1, "R5 reverse din=0");
    do_pulse(1'b1, 1'b1, "R5 reverse din=1");
    clr_win("R6 clear window, R8 outside kept");
    do_pulse(1'b1, 1'b0, "R4 refill after clear");

    // R6: clear wins over shift due at the same edge
    din = 1'b1; rev = 1'b0; pulse = 1'b1;
    step();
    clr = 1'b1;
    for (int k = hb; k < hb + lb; k++) m[k] = 1'b0;
    push("R6 clear overrides shift", 1);
    step();
    clr = 1'b0; pulse = 1'b0;
    step();

    set_cfg(250, 10, "R2 overflow flagged");
    do_pulse(1'b1, 1'b0, "R7 no shift on bad window");
    set_cfg(3, 0, "R2 zero length flagged");
    do_pulse(1'b1, 1'b1, "R7 no shift on zero length");

    set_cfg(255, 1, "R2 single top bit");
    do_pulse(1'b1, 1'b0, "R4 top bit forward");
    do_pulse(1'b0, 1'b1, "R5 top bit reverse");
    set_cfg(0, 256, "R2 full bank");
    do_pulse(1'b1, 1'b0, "R4 full bank forward");
    do_pulse(1'b1, 1'b1, "R5 full bank reverse");
    do_pulse(1'b0, 1'b1, "R5 full bank reverse din=0");

    // R10: power-down while a shift is pending
    set_cfg(4, 8, "R2 window back to 4..11");
    din = 1'b1; rev = 1'b0; pulse = 1'b1;
    step();
    pwr_down = 1'b1; mflag = 1'b1;
    push("R10 shift dropped, flag set", 1);
    step();
    pwr_down = 1'b0; pulse = 1'b0;
    step();
    push("R10 flag sticky", 2);
    step(); step();

    // R1: retention keeps bank, clears flag
    retain = 1'b1; rst_n = 1'b0; mflag = 1'b0;
    push("R1 retain keeps bank", 1);
    step(); step();
    rst_n = 1'b1;
    step();
    retain = 1'b0; rst_n = 1'b0; m = '0;
    push("R1 reset without retain clears", 1);
    step(); step();
    rst_n = 1'b1;
    step();

    repeat (4) step();
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule